// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Control Register

This block holds the two character queues that sit between a UART's serial shifters and the bus side: a receive queue and a transmit queue, each 16 entries of 8 bits by default. A single write-only control byte governs both queues. One bit enables the pair. Two self-clearing bits flush either queue on its own. A 2-bit field picks the receive fill threshold from the nonlinear set 1, 4, 8 or 14 characters.

Each queue has a push and a pop strobe, a first-word-fall-through read data port, a fill count, and empty and full flags. A data-available interrupt is raised while the pair is enabled and the receive fill count is at or above the chosen threshold. A push into a full receive queue is dropped and latches a sticky overrun flag, which a clear strobe removes. Any toggle of the enable bit flushes both queues. A flush that lands in the same cycle as a push or pop on that queue takes precedence.

Top module: `ufifo_pair`

## Requirements
- R1: After the synchronous reset `cfg_en` is 0, both counts are 0, both empty flags are 1, both full flags are 0, `rx_trig_level` is 1, and `rx_avail_irq` and `rx_overrun` are 0.
- R2: While `cfg_en` is 0, pushes and pops on either queue are ignored and the counts do not change.
- R3: A control write whose bit 0 differs from the current `cfg_en` loads the new enable value and empties both queues in the same clock edge.
- R4: A control write with bit 0 = 1 and bit 1 = 1 empties only the receive queue. The bit is not stored, so the next push is accepted normally.
- R5: A control write with bit 0 = 1 and bit 2 = 1 empties only the transmit queue. The bit is not stored.
- R6: In a control write with bit 0 = 0, bits 7:1 have no effect: the threshold keeps its value and neither flush bit acts.
- R7: Bits 7:6 of an enabled control write select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. The selected value is shown on `rx_trig_level`.
- R8: `rx_avail_irq` is 1 exactly when `cfg_en` is 1 and `rx_count` is at least `rx_trig_level`.
- R9: Each queue returns data in push order and counts from 0 to DEPTH. `empty` is set at 0 and `full` at DEPTH. A push into a full queue and a pop from an empty queue change nothing.
- R10: A dropped receive push sets `rx_overrun`. The flag stays set until a cycle with `ovr_clr` high, after which it reads 0.
- R11: When a flush and a push or pop hit the same queue in the same cycle, the queue ends empty.
- R12: Bits 5:3 of the control byte are ignored. Their value changes neither the threshold nor either queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte: bit 0 enable, bit 1 receive flush, bit 2 transmit flush, bits 5:3 ignored, bits 7:6 threshold code |
| cfg_en | output | 1 | Current enable state |
| rx_trig_level | output | 5 | Decoded receive threshold in characters |
| rx_push | input | 1 | Receive queue push strobe |
| rx_wdata | input | 8 | Receive queue push data |
| rx_pop | input | 1 | Receive queue pop strobe |
| rx_rdata | output | 8 | Receive queue head character |
| rx_count | output | 5 | Receive queue fill count |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_push | input | 1 | Transmit queue push strobe |
| tx_wdata | input | 8 | Transmit queue push data |
| tx_pop | input | 1 | Transmit queue pop strobe |
| tx_rdata | output | 8 | Transmit queue head character |
| tx_count | output | 5 | Transmit queue fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_avail_irq | output | 1 | Receive data-available interrupt |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
Each threshold code is tried with fill counts just below and exactly at its level. This separates a wrong decode from an off-by-one in the compare. Control writes that keep the enable bit, toggle it, or carry flush and reserved bits with and without enable show whether a flush was triggered by the enable edge, by the flush bit, or wrongly by a gated bit. Filling the receive queue past 16, with pushes and pops issued in the same cycle as flush writes, shows how drops, overrun and flush precedence interact. Reading back the order of distinct bytes confirms that the pointers wrap as they should.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;
  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_RXFL_BIT  = 1;
  localparam int unsigned CTRL_TXFL_BIT  = 2;
  localparam int unsigned CTRL_TRIG_LSB  = 6;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_chars(input trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/ufifo_ctrl.sv
module ufifo_ctrl
  import ufifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          wr_en_bit,
  input  logic          wr_rxfl_bit,
  input  logic          wr_txfl_bit,
  input  logic [1:0]    wr_trig,
  output logic          en_q,
  output logic          flush_rx,
  output logic          flush_tx,
  output logic [CW-1:0] trig_level
);
  trig_sel_e trig_q;
  logic      en_toggle;

  assign en_toggle = we && (wr_en_bit != en_q);
  assign flush_rx  = en_toggle || (we && wr_en_bit && wr_rxfl_bit);
  assign flush_tx  = en_toggle || (we && wr_en_bit && wr_txfl_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      trig_q <= TRIG_1;
    end else if (we) begin
      en_q <= wr_en_bit;
      if (wr_en_bit) trig_q <= trig_sel_e'(wr_trig);
    end
  end

  always_comb begin
    int unsigned lvl;
    lvl = trig_chars(trig_q);
    if (lvl > DEPTH) lvl = DEPTH;
    trig_level = CW'(lvl);
  end
endmodule

// File: rtl/ufifo_buf.sv
module ufifo_buf #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;
  logic [CW-1:0]    count_nx;

  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign drop    = push && full && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  always_comb begin
    count_nx = count;
    if (push_ok) count_nx = count_nx + CW'(1);
    if (pop_ok)  count_nx = count_nx - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count_nx;
      empty <= (count_nx == '0);
      full  <= (count_nx == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/ufifo_rx_status.sv
module ufifo_rx_status #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          drop,
  input  logic          clr,
  output logic          irq,
  output logic          overrun
);
  assign irq = en && (count >= level);

  always_ff @(posedge clk) begin
    if (rst)       overrun <= 1'b0;
    else if (drop) overrun <= 1'b1;
    else if (clr)  overrun <= 1'b0;
  end
endmodule

// File: rtl/ufifo_pair.sv
module ufifo_pair
  import ufifo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_data,
  output logic             cfg_en,
  output logic [CW-1:0]    rx_trig_level,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [CW-1:0]    rx_count,
  output logic             rx_empty,
  output logic             rx_full,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  output logic [CW-1:0]    tx_count,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             rx_avail_irq,
  output logic             rx_overrun,
  input  logic             ovr_clr
);
  logic flush_rx, flush_tx;
  logic rx_drop, tx_drop;
  logic rsvd_unused;

  assign rsvd_unused = ^{cfg_data[5:3], tx_drop};

  ufifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .we          (cfg_we),
    .wr_en_bit   (cfg_data[CTRL_EN_BIT]),
    .wr_rxfl_bit (cfg_data[CTRL_RXFL_BIT]),
    .wr_txfl_bit (cfg_data[CTRL_TXFL_BIT]),
    .wr_trig     (cfg_data[CTRL_TRIG_LSB +: 2]),
    .en_q        (cfg_en),
    .flush_rx    (flush_rx),
    .flush_tx    (flush_tx),
    .trig_level  (rx_trig_level)
  );

  ufifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush_rx),
    .push  (rx_push && cfg_en),
    .wdata (rx_wdata),
    .pop   (rx_pop && cfg_en),
    .rdata (rx_rdata),
    .count (rx_count),
    .empty (rx_empty),
    .full  (rx_full),
    .drop  (rx_drop)
  );

  ufifo_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush_tx),
    .push  (tx_push && cfg_en),
    .wdata (tx_wdata),
    .pop   (tx_pop && cfg_en),
    .rdata (tx_rdata),
    .count (tx_count),
    .empty (tx_empty),
    .full  (tx_full),
    .drop  (tx_drop)
  );

  ufifo_rx_status #(.DEPTH(DEPTH)) u_rxstat (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg_en),
    .count   (rx_count),
    .level   (rx_trig_level),
    .drop    (rx_drop),
    .clr     (ovr_clr),
    .irq     (rx_avail_irq),
    .overrun (rx_overrun)
  );
endmodule

// File: rtl/ufifo_pair_chk.sv
module ufifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          wr_en_bit,
  input logic          wr_rxfl_bit,
  input logic          cfg_en,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_push,
  input logic          tx_pop,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          rx_avail_irq,
  input logic          rx_overrun,
  input logic          ovr_clr
);
  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R9
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));

  // R8
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    rx_avail_irq |-> cfg_en);

  // R3
  en_toggle_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (wr_en_bit != cfg_en)) |=> (rx_count == '0) && (tx_count == '0));

  // R11
  rx_flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && wr_en_bit && wr_rxfl_bit && (rx_push || rx_pop)) |=> (rx_count == '0));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !ovr_clr) |=> rx_overrun);

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !cfg_we && (rx_push || rx_pop || tx_push || tx_pop))
      |=> $stable(rx_count) && $stable(tx_count));
endmodule

bind ufifo_pair ufifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .wr_en_bit    (cfg_data[0]),
  .wr_rxfl_bit  (cfg_data[1]),
  .cfg_en       (cfg_en),
  .rx_push      (rx_push),
  .rx_pop       (rx_pop),
  .tx_push      (tx_push),
  .tx_pop       (tx_pop),
  .rx_count     (rx_count),
  .tx_count     (tx_count),
  .rx_full      (rx_full),
  .rx_empty     (rx_empty),
  .rx_avail_irq (rx_avail_irq),
  .rx_overrun   (rx_overrun),
  .ovr_clr      (ovr_clr)
);

// File: tb/ufifo_pair_bench.sv
`timescale 1ns/1ps
module ufifo_pair_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       cfg_en;
  logic [4:0] rx_trig_level;
  logic       rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] rx_wdata = '0, rx_rdata;
  logic [4:0] rx_count, tx_count;
  logic       rx_empty, rx_full, tx_empty, tx_full;
  logic       tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, tx_rdata;
  logic       rx_avail_irq, rx_overrun;
  logic       ovr_clr = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ufifo_pair u_ufifo_pair (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cfg_en(cfg_en), .rx_trig_level(rx_trig_level),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_avail_irq(rx_avail_irq), .rx_overrun(rx_overrun), .ovr_clr(ovr_clr)
  );

  // vector: {we, cfg[7:0], rx_push, rx_pop, exp_rx_count[4:0], exp_irq}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h01, 1'b0, 1'b0, 5'd0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd1, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd2, 1'b1},
    {1'b1, 8'h41, 1'b0, 1'b0, 5'd2, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd3, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd4, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1, 5'd3, 1'b0},
    {1'b1, 8'h43, 1'b0, 1'b0, 5'd0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd1, 1'b0},
    {1'b1, 8'h81, 1'b0, 1'b0, 5'd1, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 5'd0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 5'd0, 1'b0},
    {1'b1, 8'hC1, 1'b0, 1'b0, 5'd0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    tx_push = 1'b0; tx_pop = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_data = v; tick();
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d; tick();
  endtask

  task automatic reset_checks(input string tag);
    chk({tag, " R1 en"}, cfg_en, 0);
    chk({tag, " R1 rx_count"}, rx_count, 0);
    chk({tag, " R1 tx_count"}, tx_count, 0);
    chk({tag, " R1 empties"}, {rx_empty, tx_empty}, 3);
    chk({tag, " R1 fulls"}, {rx_full, tx_full}, 0);
    chk({tag, " R1 trig"}, rx_trig_level, 1);
    chk({tag, " R1 irq/ovr"}, {rx_avail_irq, rx_overrun}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_checks("initial");

    // table walk: R7 R8 R9 R3 R2 R4
    for (int i = 0; i < NV; i++) begin
      cfg_we   = VEC[i][16];
      cfg_data = VEC[i][15:8];
      rx_push  = VEC[i][7];
      rx_pop   = VEC[i][6];
      rx_wdata = 8'(i);
      tick();
      chk($sformatf("vec%0d R9 R3 rx_count", i), rx_count, VEC[i][5:1]);
      chk($sformatf("vec%0d R8 irq", i), rx_avail_irq, VEC[i][0]);
    end

    // threshold 14 boundary, fill, overrun, order
    chk("R7 trig14", rx_trig_level, 14);
    for (int i = 0; i < 13; i++) rxp(8'h10 + 8'(i));
    chk("R8 13 below 14", rx_avail_irq, 0);
    rxp(8'h1D);
    chk("R8 at 14", rx_avail_irq, 1);
    rxp(8'h1E); rxp(8'h1F);
    chk("R9 full count", rx_count, 16);
    chk("R9 full flag", {rx_full, rx_empty}, 2);
    chk("R10 no ovr yet", rx_overrun, 0);
    rxp(8'hEE);
    chk("R9 drop count", rx_count, 16);
    chk("R10 ovr set", rx_overrun, 1);
    tick();
    chk("R10 ovr sticky", rx_overrun, 1);
    chk("R9 head", rx_rdata, 8'h10);
    rx_pop = 1'b1; tick();
    chk("R9 order", rx_rdata, 8'h11);
    chk("R9 pop count", rx_count, 15);
    ovr_clr = 1'b1; tick();
    chk("R10 ovr clr", rx_overrun, 0);

    // flush beats push (R11, R4)
    cfg_we = 1'b1; cfg_data = 8'hC3; rx_push = 1'b1; rx_wdata = 8'h55; tick();
    chk("R11 flush wins", rx_count, 0);
    chk("R4 empty", rx_empty, 1);
    rxp(8'h66);
    tick();
    chk("R4 self clear", rx_count, 1);
    chk("R4 data", rx_rdata, 8'h66);

    // transmit queue and its flush (R5)
    tx_push = 1'b1; tx_wdata = 8'hA1; tick();
    tx_push = 1'b1; tx_wdata = 8'hA2; tick();
    tx_push = 1'b1; tx_wdata = 8'hA3; tick();
    chk("R9 tx count", tx_count, 3);
    tx_pop = 1'b1; tick();
    chk("R9 tx order", tx_rdata, 8'hA2);
    cfg_we = 1'b1; cfg_data = 8'hC5; tx_pop = 1'b1; tick();
    chk("R5 tx flushed", tx_count, 0);
    chk("R5 rx kept", rx_count, 1);
    tx_push = 1'b1; tx_wdata = 8'hB0; tick();
    chk("R5 self clear", tx_count, 1);

    // reserved bits (R12)
    wcfg(8'hF9);
    chk("R12 rx kept", rx_count, 1);
    chk("R12 tx kept", tx_count, 1);
    chk("R12 trig", rx_trig_level, 14);
    wcfg(8'h39);
    chk("R12 R7 trig1", rx_trig_level, 1);
    chk("R8 irq at 1", rx_avail_irq, 1);
    wcfg(8'h41);
    chk("R7 trig4", rx_trig_level, 4);
    wcfg(8'h81);
    chk("R7 trig8", rx_trig_level, 8);

    // disable with gated bits (R3 R6 R2)
    wcfg(8'hC6);
    chk("R3 en off", cfg_en, 0);
    chk("R3 both flushed", {rx_count, tx_count}, 0);
    chk("R6 trig kept", rx_trig_level, 8);
    chk("R8 irq off", rx_avail_irq, 0);
    rx_push = 1'b1; tx_push = 1'b1; tick();
    chk("R2 push ignored", {rx_count, tx_count}, 0);
    wcfg(8'h01);
    chk("R3 en on", cfg_en, 1);
    rx_pop = 1'b1; tick();
    chk("R9 pop empty", {rx_count, 5'(rx_empty)}, 1);

    // mid-run reset
    rxp(8'h01);
    tx_push = 1'b1; tick();
    rst = 1'b1; tick();
    rst = 1'b0;
    reset_checks("midrun");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule